// File: doc/BRIEF.md
# Frequency-Locked PWM Generator with Glitch-Free Duty Update

This block produces a single pulse-width-modulated output from a fixed reference clock of `CLK_HZ` hertz. A host supplies a 16-bit frequency word in steps of 0.1 Hz and a 16-bit duty word in steps of 0.1 %. A one-cycle start pulse latches both words. The block then works out the period and the high time, using one shared iterative divider, and starts driving the output. The output goes high at the start of each period and stays high for the computed high time.

While the output runs, the frequency is fixed. A further start pulse changes only the duty. The new high time is worked out in the background and takes effect at the next period boundary. The pulse in progress is never cut short and the waveform never pauses. A stop pulse or the global mode-reset input ends the run at once.

All pins are plain control and status signals. No data stream crosses the block edge, so there is no valid/ready handshake. Start must be a single-cycle pulse, because every start sampled while idle begins a new run.

Top module: `pwm_gen`

## Requirements
- R1: While running, the output period in reference-clock cycles equals trunc(CLK_HZ*10 / F), where F is the frequency word latched at the start that began the run.
- R2: Each period begins with the output high for trunc(period*D/1000) cycles, then the output is low for the rest of the period. D is the active duty value.
- R3: A duty word above 1000 is treated as 1000. With D=0 the output stays low for the whole run, and with D=1000 it stays high.
- R4: A start pulse while idle with a frequency word of 0 is rejected, and busy stays low.
- R5: A start pulse while busy ignores the frequency word. The period stays unchanged and the output keeps running.
- R6: The duty word of a start pulse while busy takes effect at a period boundary. The period in progress completes with its old high time, and no period is skipped or stretched.
- R7: At the clock edge that samples stop high, busy and the output both go low. They stay low until the next accepted start. Stop wins over a start in the same cycle.
- R8: The mode-reset input has the same effect as stop.
- R9: An accepted start (F not 0, no stop or mode reset in the same cycle) sets busy at the next edge. While busy is low, the output is low.
- R10: After the asynchronous reset, the output and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, CLK_HZ hertz |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_rst | input | 1 | Global mode reset; ends the run like stop |
| start | input | 1 | One-cycle start pulse; while busy it requests a duty change |
| stop | input | 1 | One-cycle stop pulse |
| freq_word | input | 16 | Frequency in 0.1 Hz steps, 1 to 65535 |
| duty_word | input | 16 | Duty in 0.1 % steps, 0 to 1000 (larger values are clamped) |
| pwm_out | output | 1 | PWM output |
| busy | output | 1 | High from an accepted start until stop or mode reset |

## Verification
The hardest case is a duty change that arrives early in a period, while the pulse in progress is still high. A design that applies the new duty at once would cut that pulse short. To reach this case, the bench waits for a rising edge of the output and issues the duty-changing start in that same cycle. It counts the width of that pulse, which must keep the old high time. It then checks that a later period carries the new width while every period keeps its length.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Full-scale duty value (100.0 % in 0.1 % steps)
  localparam int unsigned DUTY_FULL = 1000;
  localparam int unsigned DQ_W      = $clog2(DUTY_FULL + 1);

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_CALC_P = 2'd1,
    S_CALC_H = 2'd2,
    S_RUN    = 2'd3
  } pwm_state_e;

  function automatic logic [DQ_W-1:0] duty_clamp(input logic [15:0] d);
    if (d > 16'(DUTY_FULL)) return DQ_W'(DUTY_FULL);
    return d[DQ_W-1:0];
  endfunction

endpackage

// File: rtl/pwm_div.sv
// Iterative restoring divider: one quotient bit per clock, W cycles per result.
module pwm_div #(
  parameter int unsigned W = 29
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  n_sh;
  logic [W-1:0]  rem;
  logic [W-1:0]  d_q;
  logic [W-1:0]  q;
  logic [CW-1:0] steps;
  logic          act;
  logic [W:0]    trial;

  assign trial = {rem, n_sh[W-1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_sh  <= '0;
      rem   <= '0;
      d_q   <= '0;
      q     <= '0;
      steps <= '0;
      act   <= 1'b0;
      done  <= 1'b0;
    end else if (clr) begin
      act  <= 1'b0;
      done <= 1'b0;
    end else if (go) begin
      n_sh  <= num;
      d_q   <= den;
      rem   <= '0;
      q     <= '0;
      steps <= CW'(W);
      act   <= 1'b1;
      done  <= 1'b0;
    end else if (act) begin
      n_sh <= {n_sh[W-2:0], 1'b0};
      if (trial >= {1'b0, d_q}) begin
        rem <= W'(trial - {1'b0, d_q});
        q   <= {q[W-2:0], 1'b1};
      end else begin
        rem <= trial[W-1:0];
        q   <= {q[W-2:0], 1'b0};
      end
      steps <= steps - 1'b1;
      if (steps == CW'(1)) begin
        act  <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign busy = act;
  assign quot = q;

endmodule

// File: rtl/pwm_wave.sv
// Period counter and compare; a staged high time is adopted only on wrap.
module pwm_wave #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_high,
  input  logic [CNT_W-1:0] period,
  input  logic             nxt_we,
  input  logic [CNT_W-1:0] nxt_high,
  output logic             pwm_out
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] high_cur;
  logic [CNT_W-1:0] high_nxt;
  logic             nxt_v;
  logic             run;
  logic             wrap;

  assign wrap = (cnt == period - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      high_cur <= '0;
      high_nxt <= '0;
      nxt_v    <= 1'b0;
      run      <= 1'b0;
    end else if (clr) begin
      cnt   <= '0;
      nxt_v <= 1'b0;
      run   <= 1'b0;
    end else if (load) begin
      cnt      <= '0;
      high_cur <= load_high;
      nxt_v    <= 1'b0;
      run      <= 1'b1;
    end else if (run) begin
      if (wrap) begin
        cnt <= '0;
        if (nxt_v) begin
          high_cur <= high_nxt;
          nxt_v    <= 1'b0;
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
      if (nxt_we) begin
        high_nxt <= nxt_high;
        nxt_v    <= 1'b1;
      end
    end
  end

  assign pwm_out = run && (cnt < high_cur);

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50000,
  parameter int unsigned FREQ_W = 16,
  parameter int unsigned DUTY_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_rst,
  input  logic              start,
  input  logic              stop,
  input  logic [FREQ_W-1:0] freq_word,
  input  logic [DUTY_W-1:0] duty_word,
  output logic              pwm_out,
  output logic              busy
);
  localparam int unsigned NUM_P = CLK_HZ * 10;
  localparam int unsigned CNT_W = $clog2(NUM_P + 1);
  localparam int unsigned DW    = CNT_W + DQ_W;

  pwm_state_e       state;
  logic [FREQ_W-1:0] freq_q;
  logic [DQ_W-1:0]  duty_req;
  logic [CNT_W-1:0] period_q;
  logic             dirty;
  logic             sel_h;
  logic             go_q;
  logic             kill;
  logic             div_busy;
  logic             div_done;
  logic [DW-1:0]    quot;
  logic [DW-1:0]    num;
  logic [DW-1:0]    den;
  logic             wave_load;
  logic             pend_we;

  assign kill = stop | mode_rst;
  assign busy = (state != S_IDLE);

  assign num = sel_h ? (DW'(period_q) * DW'(duty_req)) : DW'(NUM_P);
  assign den = sel_h ? DW'(DUTY_FULL) : DW'(freq_q);

  assign wave_load = (state == S_CALC_H) && div_done;
  assign pend_we   = (state == S_RUN) && div_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      freq_q   <= '0;
      duty_req <= '0;
      period_q <= '0;
      dirty    <= 1'b0;
      sel_h    <= 1'b0;
      go_q     <= 1'b0;
    end else if (kill) begin
      state <= S_IDLE;
      dirty <= 1'b0;
      go_q  <= 1'b0;
    end else begin
      go_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start && (freq_word != '0)) begin
            freq_q   <= freq_word;
            duty_req <= duty_clamp(16'(duty_word));
            sel_h    <= 1'b0;
            go_q     <= 1'b1;
            state    <= S_CALC_P;
          end
        end
        S_CALC_P: begin
          if (div_done) begin
            period_q <= CNT_W'(quot);
            sel_h    <= 1'b1;
            go_q     <= 1'b1;
            dirty    <= 1'b0;
            state    <= S_CALC_H;
          end
        end
        S_CALC_H: begin
          if (div_done) state <= S_RUN;
        end
        S_RUN: begin
          if (dirty && !div_busy && !go_q) begin
            go_q  <= 1'b1;
            dirty <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
      // Start while busy: duty only, frequency word is not looked at
      if ((state != S_IDLE) && start) begin
        duty_req <= duty_clamp(16'(duty_word));
        dirty    <= 1'b1;
      end
    end
  end

  pwm_div #(.W(DW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (kill),
    .go    (go_q),
    .num   (num),
    .den   (den),
    .busy  (div_busy),
    .done  (div_done),
    .quot  (quot)
  );

  pwm_wave #(.CNT_W(CNT_W)) u_wave (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (kill),
    .load      (wave_load),
    .load_high (CNT_W'(quot)),
    .period    (period_q),
    .nxt_we    (pend_we),
    .nxt_high  (CNT_W'(quot)),
    .pwm_out   (pwm_out)
  );

endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk
  import pwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 19,
  parameter int unsigned FREQ_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_rst,
  input logic              start,
  input logic              stop,
  input logic [FREQ_W-1:0] freq_word,
  input logic              pwm_out,
  input logic              busy,
  input pwm_state_e        state,
  input logic [CNT_W-1:0]  period_q
);

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pwm_out);

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (freq_word != '0) && !stop && !mode_rst) |=> busy);

  assert_zero_freq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (freq_word == '0)) |=> !busy);

  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!busy && !pwm_out));

  assert_mode_rst_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rst |=> (!busy && !pwm_out));

  assert_freq_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_RUN) && ($past(state) == S_RUN)) |-> $stable(period_q));

endmodule

bind pwm_gen pwm_gen_chk #(.CNT_W(CNT_W), .FREQ_W(FREQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_rst  (mode_rst),
  .start     (start),
  .stop      (stop),
  .freq_word (freq_word),
  .pwm_out   (pwm_out),
  .busy      (busy),
  .state     (state),
  .period_q  (period_q)
);

// File: tb/sim_pwm_gen.sv
module sim_pwm_gen;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_rst = 1'b0;
  logic        start = 1'b0;
  logic        stop = 1'b0;
  logic [15:0] freq_word = '0;
  logic [15:0] duty_word = '0;
  logic        pwm_out;
  logic        busy;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_gen #(.CLK_HZ(CLK_HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_rst(mode_rst), .start(start), .stop(stop),
    .freq_word(freq_word), .duty_word(duty_word), .pwm_out(pwm_out), .busy(busy)
  );

  function automatic int exp_per(int f);
    return (CLK_HZ * 10) / f;
  endfunction

  function automatic int exp_hi(int p, int d);
    int dc = (d > 1000) ? 1000 : d;
    return (p * dc) / 1000;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_start(input int f, input int d);
    @(negedge clk);
    start = 1'b1; freq_word = 16'(f); duty_word = 16'(d);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic wait_rise(output bit ok);
    bit prev = pwm_out;
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (pwm_out && !prev) begin ok = 1'b1; return; end
      prev = pwm_out;
    end
  endtask

  // Called at the sample where a rise was seen; measures that pulse and period.
  task automatic measure(input bit upd, input int ud, input int uf,
                         output int hi, output int per);
    bit fell = 1'b0;
    hi = 1; per = 1;
    if (upd) begin start = 1'b1; duty_word = 16'(ud); freq_word = 16'(uf); end
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (pwm_out) begin
        if (fell) break;
        hi++;
      end else begin
        fell = 1'b1;
      end
      per++;
    end
  endtask

  task automatic t_reset();
    check(pwm_out == 1'b0, "R10 out after reset", pwm_out, 0);
    check(busy == 1'b0, "R10 busy after reset", busy, 0);
  endtask

  task automatic t_basic(input int f, input int d);
    bit ok; int hi, per;
    do_stop();
    do_start(f, d);
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    wait_rise(ok);
    check(ok, "R2 first rise seen", ok, 1);
    measure(0, 0, 0, hi, per);
    wait_rise(ok);
    measure(0, 0, 0, hi, per);
    check(per == exp_per(f), "R1 period", per, exp_per(f));
    check(hi == exp_hi(exp_per(f), d), "R2 high time", hi, exp_hi(exp_per(f), d));
  endtask

  task automatic t_freq_locked();
    bit ok; int hi, per;
    do_stop();
    do_start(5000, 500);
    wait_rise(ok);
    measure(1, 500, 10000, hi, per);
    check(per == 100, "R5 period after freq change attempt", per, 100);
    measure(0, 0, 0, hi, per);
    check(per == 100, "R5 period stays locked", per, 100);
    measure(0, 0, 0, hi, per);
    check(per == 100 && hi == 50, "R5 waveform unchanged", per, 100);
    check(busy == 1'b1, "R5 still busy", busy, 1);
  endtask

  task automatic t_duty_update();
    bit ok; int hi, per;
    do_stop();
    do_start(5000, 700);
    wait_rise(ok);
    measure(1, 200, 9999, hi, per);
    check(hi == 70, "R6 pulse in progress keeps old width", hi, 70);
    check(per == 100, "R6 period in progress not stretched", per, 100);
    measure(0, 0, 0, hi, per);
    check(per == 100, "R6 boundary period length", per, 100);
    measure(0, 0, 0, hi, per);
    check(hi == 20, "R6 new width applied", hi, 20);
    check(per == 100, "R6 period after update", per, 100);
  endtask

  task automatic t_constant(input int d, input bit level);
    int bad = 0;
    do_stop();
    do_start(5000, d);
    repeat (150) @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwm_out != level || !busy) bad++;
    end
    check(bad == 0, "R3 constant level", bad, 0);
  endtask

  task automatic t_zero_freq();
    int bad = 0;
    do_stop();
    do_start(0, 500);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (busy || pwm_out) bad++;
    end
    check(bad == 0, "R4 zero frequency rejected", bad, 0);
  endtask

  task automatic t_kill(input bit use_mode);
    bit ok; int bad = 0;
    do_stop();
    do_start(5000, 500);
    wait_rise(ok);
    if (use_mode) mode_rst = 1'b1; else stop = 1'b1;
    @(negedge clk);
    mode_rst = 1'b0; stop = 1'b0;
    if (use_mode) begin
      check(pwm_out == 1'b0, "R8 out low after mode reset", pwm_out, 0);
      check(busy == 1'b0, "R8 busy low after mode reset", busy, 0);
    end else begin
      check(pwm_out == 1'b0, "R7 out low after stop", pwm_out, 0);
      check(busy == 1'b0, "R7 busy low after stop", busy, 0);
    end
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwm_out || busy) bad++;
    end
    check(bad == 0, use_mode ? "R8 stays idle" : "R7 stays idle", bad, 0);
  endtask

  task automatic t_stop_wins();
    @(negedge clk);
    start = 1'b1; stop = 1'b1; freq_word = 16'd5000; duty_word = 16'd500;
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
    check(busy == 1'b0, "R7 stop wins over start", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic(5000, 250);
    t_basic(7000, 333);
    t_basic(20000, 125);
    t_freq_locked();
    t_duty_update();
    t_constant(0, 1'b0);
    t_constant(1000, 1'b1);
    t_constant(16'hFFFF, 1'b1);
    t_zero_freq();
    t_kill(1'b0);
    t_kill(1'b1);
    t_stop_wins();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule